// File: doc/BRIEF.md
# Video encoder command port

This block is the host-facing command port of a video encoder. The host talks to it over a byte-wide bus in two phases. In the instruction phase it strobes a 4-bit opcode onto the low bus bits. In the data phase it either strobes a data byte into the register that the opcode selects, or reads back a status byte while the port drives the bus. The configuration it holds goes straight to the encoder datapath: a variance threshold, the inter and intra quantisers, a setup word and a control word. The status it returns comes from the datapath: the GOB number, the macroblock number with a "changing" flag, and the per-macroblock decision flags.

Quantiser and control writes go into shadow copies first. A copy reaches the live output only on the next macroblock boundary pulse, so a macroblock that is already being coded never sees a half-changed setting. Before writing, the host can read the macroblock number and check its changing flag to pick a safe moment.

The port is built around a three-state machine: `ST_IDLE` (no opcode held), `ST_ARMED` (an opcode is latched and the port waits for the data phase) and `ST_READ` (the port is driving the bus). The transitions are as follows:
- A valid instruction strobe moves any state to `ST_ARMED`.
- An instruction strobe with a nonzero upper nibble moves any state to `ST_IDLE`.
- In `ST_ARMED`, a data phase with a read opcode moves to `ST_READ`.
- In `ST_ARMED`, a data strobe with a write or unknown opcode moves to `ST_IDLE`.
- In `ST_READ`, dropping the select or the phase line moves to `ST_IDLE`.

Top module: `enc_ctl_port`

## Requirements
- R1: After reset the threshold output is 3 shifted into the top 8 of 14 bits (192). Both quantiser outputs are 62, the setup and control outputs are 0, and `bus_oe` is 0.
- R2: An instruction strobe is a cycle with `host_sel`=1, `host_dphase`=0 and `host_stb`=1. On it the port latches `bus_in[3:0]` as the opcode. If `bus_in[7:4]` is nonzero, the port discards the instruction, and a following data strobe changes nothing.
- R3: Opcode 1 writes the inter quantiser as `{bus_in[4:0],0}`, which gives an even value from 0 to 62. The value appears on `q_inter_o` only at the clock edge where `mb_boundary` is 1. A write made in that same cycle waits for the next boundary.
- R4: When setup bit 3 is 0, `q_intra_o` equals `q_inter_o`. When it is 1, `q_intra_o` is the live intra quantiser, which opcode 2 writes with the same encoding and shadowing as R3.
- R5: Opcode 3 writes the setup word at once. Only bits 0 (QCIF), 3 (separate quantisers), 5 (no motion compensation) and 6 (large DRAM) are kept, and bits 1, 2, 4 and 7 are stored as 0. Opcode 11 reads the setup word back with the same layout.
- R6: Opcode 0 writes the 8-bit threshold at once. `var_thresh_o` is that byte followed by six zero bits.
- R7: Opcode 4 writes the 8-bit control word into a shadow copy. The copy reaches `ctrl_o` at the next `mb_boundary` edge.
- R8: Opcode 8 reads `{0000, gob_num}`.
- R9: Opcode 9 reads `mb_num` on bits 5:0, the inverse of `mb_changing` on bit 6, and 0 on bit 7.
- R10: Opcode 10 reads the decision flags with this mapping:

| `mb_flags` bit | Meaning | Bus bit |
|---|---|---|
| 0 | inter (1) / intra (0) | 0 |
| 1 | motion compensation used | 1 |
| 2 | filtered | 3 |
| 3 | fixed macroblock | 4 |
| 4 | fast update | 5 |
| 5 | skip frame | 6 |

  Bus bits 2 and 7 read 0.
- R11: `bus_oe` is 1 only in `ST_READ` while `host_sel` and `host_dphase` are both 1. It drops in the same cycle that either line falls. `ST_READ` is entered on the clock edge after the data phase is first presented. `bus_out` is 0 whenever `bus_oe` is 0.
- R12: Opcodes 5–7 and 12–15 change no register, and they never drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| host_sel | input | 1 | host access enable |
| host_dphase | input | 1 | 0 instruction phase, 1 data phase |
| host_stb | input | 1 | one-cycle strobe |
| bus_in | input | 8 | byte from host |
| bus_out | output | 8 | byte to host |
| bus_oe | output | 1 | bus driver enable |
| mb_boundary | input | 1 | macroblock boundary pulse |
| gob_num | input | 4 | current GOB number |
| mb_num | input | 6 | current macroblock number |
| mb_changing | input | 1 | macroblock number changing or about to |
| mb_flags | input | 6 | per-macroblock decision flags |
| var_thresh_o | output | 14 | variance threshold comparison value |
| q_inter_o | output | 6 | live inter quantiser |
| q_intra_o | output | 6 | effective intra quantiser |
| setup_o | output | 8 | setup word |
| ctrl_o | output | 8 | live control word |

## Verification
The bench builds the block with its defaults: a 6-bit quantiser, an 8-bit threshold placed in a 14-bit value with a reset value of 3, a 4-bit GOB number and a 6-bit macroblock number. With these widths the full quantiser range can be reached, including the 62 reset maximum and the dropping of bus bits 7:5. They also put every read layout on the same byte positions that the host decodes. A write that lands in the same cycle as a boundary pulse is driven on purpose, to check that it waits for the following boundary.

// File: rtl/enc_ctl_pkg.sv
package enc_ctl_pkg;

    localparam int BUS_W = 8;
    localparam int OP_W  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_READ  = 2'd2
    } port_state_t;

    localparam logic [OP_W-1:0] OP_THR      = 4'd0;
    localparam logic [OP_W-1:0] OP_QINTER   = 4'd1;
    localparam logic [OP_W-1:0] OP_QINTRA   = 4'd2;
    localparam logic [OP_W-1:0] OP_SETUP    = 4'd3;
    localparam logic [OP_W-1:0] OP_CTRL     = 4'd4;
    localparam logic [OP_W-1:0] OP_RD_GOB   = 4'd8;
    localparam logic [OP_W-1:0] OP_RD_MB    = 4'd9;
    localparam logic [OP_W-1:0] OP_RD_DEC   = 4'd10;
    localparam logic [OP_W-1:0] OP_RD_SETUP = 4'd11;

    // setup bits kept: 0 qcif, 3 split quantisers, 5 no motion comp, 6 big dram
    localparam logic [BUS_W-1:0] SETUP_MASK = 8'h69;
    localparam int SETUP_SPLIT_BIT = 3;
    localparam int MB_FLAG_BIT     = 6;

    function automatic logic op_is_read(input logic [OP_W-1:0] op);
        return (op == OP_RD_GOB) || (op == OP_RD_MB) ||
               (op == OP_RD_DEC) || (op == OP_RD_SETUP);
    endfunction

    function automatic logic op_is_write(input logic [OP_W-1:0] op);
        return op <= OP_CTRL;
    endfunction

endpackage

// File: rtl/enc_ctl_fsm.sv
module enc_ctl_fsm
    import enc_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_sel,
    input  logic                host_dphase,
    input  logic                host_stb,
    input  logic [BUS_W-1:0]    bus_in,
    output logic [OP_W-1:0]     op_q,
    output logic                wr_pulse,
    output logic                drive_en
);

    port_state_t state_q, state_d;
    logic        ins_stb, ins_ok, data_ph;

    assign ins_stb = host_sel && !host_dphase && host_stb;
    assign ins_ok  = ins_stb && (bus_in[BUS_W-1:OP_W] == '0);
    assign data_ph = host_sel && host_dphase;

    // state register and opcode latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= '0;
        end else begin
            state_q <= state_d;
            if (ins_ok) op_q <= bus_in[OP_W-1:0];
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (ins_stb) begin
            state_d = ins_ok ? ST_ARMED : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_ARMED: begin
                    if (data_ph) begin
                        if (op_is_read(op_q))  state_d = ST_READ;
                        else if (host_stb)     state_d = ST_IDLE;
                    end
                end
                ST_READ:  if (!data_ph) state_d = ST_IDLE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_pulse = (state_q == ST_ARMED) && data_ph && host_stb && op_is_write(op_q);
        drive_en = (state_q == ST_READ) && data_ph;
    end

endmodule

// File: rtl/enc_ctl_regs.sv
module enc_ctl_regs
    import enc_ctl_pkg::*;
#(
    parameter int QW      = 6,
    parameter int THR_W   = 8,
    parameter int CMP_W   = 14,
    parameter int THR_RST = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_pulse,
    input  logic [OP_W-1:0]     op,
    input  logic [BUS_W-1:0]    din,
    input  logic                mb_boundary,
    output logic [CMP_W-1:0]    var_thresh_o,
    output logic [QW-1:0]       q_inter_o,
    output logic [QW-1:0]       q_intra_o,
    output logic [BUS_W-1:0]    setup_o,
    output logic [BUS_W-1:0]    ctrl_o
);

    localparam int PAD_W = CMP_W - THR_W;
    localparam logic [QW-1:0] Q_MAX = {{(QW-1){1'b1}}, 1'b0};

    logic [THR_W-1:0] thr_q;
    logic [BUS_W-1:0] setup_q;
    logic [QW-1:0]    qi_sh, qa_sh, qi_live, qa_live;
    logic [BUS_W-1:0] ctrl_sh, ctrl_live;
    logic [QW-1:0]    q_wr_val;

    assign q_wr_val = {din[QW-2:0], 1'b0};

    // immediate registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q   <= THR_W'(THR_RST);
            setup_q <= '0;
        end else if (wr_pulse) begin
            if (op == OP_THR)   thr_q   <= din[THR_W-1:0];
            if (op == OP_SETUP) setup_q <= din & SETUP_MASK;
        end
    end

    // shadowed registers: live copies move on the macroblock boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qi_sh     <= Q_MAX;
            qa_sh     <= Q_MAX;
            ctrl_sh   <= '0;
            qi_live   <= Q_MAX;
            qa_live   <= Q_MAX;
            ctrl_live <= '0;
        end else begin
            if (mb_boundary) begin
                qi_live   <= qi_sh;
                qa_live   <= qa_sh;
                ctrl_live <= ctrl_sh;
            end
            if (wr_pulse) begin
                if (op == OP_QINTER) qi_sh   <= q_wr_val;
                if (op == OP_QINTRA) qa_sh   <= q_wr_val;
                if (op == OP_CTRL)   ctrl_sh <= din;
            end
        end
    end

    assign var_thresh_o = {thr_q, {PAD_W{1'b0}}};
    assign q_inter_o    = qi_live;
    assign q_intra_o    = setup_q[SETUP_SPLIT_BIT] ? qa_live : qi_live;
    assign setup_o      = setup_q;
    assign ctrl_o       = ctrl_live;

endmodule

// File: rtl/enc_ctl_rdmux.sv
module enc_ctl_rdmux
    import enc_ctl_pkg::*;
#(
    parameter int GOB_W = 4,
    parameter int MB_W  = 6
) (
    input  logic [OP_W-1:0]   op,
    input  logic              drive_en,
    input  logic [GOB_W-1:0]  gob_num,
    input  logic [MB_W-1:0]   mb_num,
    input  logic              mb_changing,
    input  logic [5:0]        mb_flags,
    input  logic [BUS_W-1:0]  setup_w,
    output logic [BUS_W-1:0]  bus_out
);

    always_comb begin
        bus_out = '0;
        if (drive_en) begin
            unique case (op)
                OP_RD_GOB:   bus_out[GOB_W-1:0] = gob_num;
                OP_RD_MB: begin
                    bus_out[MB_W-1:0]  = mb_num;
                    bus_out[MB_FLAG_BIT] = ~mb_changing;
                end
                OP_RD_DEC:   bus_out = {1'b0, mb_flags[5:2], 1'b0, mb_flags[1:0]};
                OP_RD_SETUP: bus_out = setup_w;
                default:     bus_out = '0;
            endcase
        end
    end

endmodule

// File: rtl/enc_ctl_port.sv
module enc_ctl_port
    import enc_ctl_pkg::*;
#(
    parameter int QW      = 6,
    parameter int THR_W   = 8,
    parameter int CMP_W   = 14,
    parameter int THR_RST = 3,
    parameter int GOB_W   = 4,
    parameter int MB_W    = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_sel,
    input  logic               host_dphase,
    input  logic               host_stb,
    input  logic [7:0]         bus_in,
    output logic [7:0]         bus_out,
    output logic               bus_oe,
    input  logic               mb_boundary,
    input  logic [GOB_W-1:0]   gob_num,
    input  logic [MB_W-1:0]    mb_num,
    input  logic               mb_changing,
    input  logic [5:0]         mb_flags,
    output logic [CMP_W-1:0]   var_thresh_o,
    output logic [QW-1:0]      q_inter_o,
    output logic [QW-1:0]      q_intra_o,
    output logic [7:0]         setup_o,
    output logic [7:0]         ctrl_o
);

    logic [OP_W-1:0] op_q;
    logic            wr_pulse, drive_en;

    enc_ctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_sel    (host_sel),
        .host_dphase (host_dphase),
        .host_stb    (host_stb),
        .bus_in      (bus_in),
        .op_q        (op_q),
        .wr_pulse    (wr_pulse),
        .drive_en    (drive_en)
    );

    enc_ctl_regs #(
        .QW(QW), .THR_W(THR_W), .CMP_W(CMP_W), .THR_RST(THR_RST)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_pulse     (wr_pulse),
        .op           (op_q),
        .din          (bus_in),
        .mb_boundary  (mb_boundary),
        .var_thresh_o (var_thresh_o),
        .q_inter_o    (q_inter_o),
        .q_intra_o    (q_intra_o),
        .setup_o      (setup_o),
        .ctrl_o       (ctrl_o)
    );

    enc_ctl_rdmux #(.GOB_W(GOB_W), .MB_W(MB_W)) u_rdmux (
        .op          (op_q),
        .drive_en    (drive_en),
        .gob_num     (gob_num),
        .mb_num      (mb_num),
        .mb_changing (mb_changing),
        .mb_flags    (mb_flags),
        .setup_w     (setup_o),
        .bus_out     (bus_out)
    );

    assign bus_oe = drive_en;

endmodule

// File: rtl/enc_ctl_port_chk.sv
module enc_ctl_port_chk #(
    parameter int QW    = 6,
    parameter int THR_W = 8,
    parameter int CMP_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_sel,
    input logic             host_dphase,
    input logic [7:0]       bus_out,
    input logic             bus_oe,
    input logic             mb_boundary,
    input logic [CMP_W-1:0] var_thresh_o,
    input logic [QW-1:0]    q_inter_o,
    input logic [QW-1:0]    q_intra_o,
    input logic [7:0]       setup_o,
    input logic [7:0]       ctrl_o
);

    p_quant_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q_inter_o[0] == 1'b0);

    p_quant_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mb_boundary |=> $stable(q_inter_o));

    p_intra_shared_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !setup_o[3] |-> (q_intra_o == q_inter_o));

    p_setup_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_o & 8'h96) == 8'h00);

    p_thr_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
        var_thresh_o[CMP_W-THR_W-1:0] == '0);

    p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mb_boundary |=> $stable(ctrl_o));

    p_bus_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_sel && host_dphase) |-> !bus_oe);

    p_bus_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == 8'h00));

endmodule

bind enc_ctl_port enc_ctl_port_chk #(.QW(QW), .THR_W(THR_W), .CMP_W(CMP_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_sel     (host_sel),
    .host_dphase  (host_dphase),
    .bus_out      (bus_out),
    .bus_oe       (bus_oe),
    .mb_boundary  (mb_boundary),
    .var_thresh_o (var_thresh_o),
    .q_inter_o    (q_inter_o),
    .q_intra_o    (q_intra_o),
    .setup_o      (setup_o),
    .ctrl_o       (ctrl_o)
);

// File: tb/enc_ctl_port_test.sv
module enc_ctl_port_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_sel = 1'b0, host_dphase = 1'b0, host_stb = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic mb_boundary = 1'b0;
    logic [3:0] gob_num = 4'h0;
    logic [5:0] mb_num = 6'h0;
    logic mb_changing = 1'b0;
    logic [5:0] mb_flags = 6'h0;
    logic [7:0] bus_out;
    logic bus_oe;
    logic [13:0] var_thresh_o;
    logic [5:0] q_inter_o, q_intra_o;
    logic [7:0] setup_o, ctrl_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    enc_ctl_port uut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_dphase(host_dphase),
        .host_stb(host_stb), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .mb_boundary(mb_boundary), .gob_num(gob_num), .mb_num(mb_num),
        .mb_changing(mb_changing), .mb_flags(mb_flags), .var_thresh_o(var_thresh_o),
        .q_inter_o(q_inter_o), .q_intra_o(q_intra_o), .setup_o(setup_o), .ctrl_o(ctrl_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model: 0 idle, 1 armed, 2 reading
    int         m_st;
    logic [3:0] m_op;
    logic [7:0] m_thr, m_setup, m_ctrl, m_ctrl_sh;
    logic [5:0] m_qi, m_qa, m_qi_sh, m_qa_sh;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_op = 0; m_thr = 8'd3; m_setup = 0; m_ctrl = 0; m_ctrl_sh = 0;
            m_qi = 6'd62; m_qa = 6'd62; m_qi_sh = 6'd62; m_qa_sh = 6'd62;
        end else begin
            if (mb_boundary) begin
                m_qi = m_qi_sh; m_qa = m_qa_sh; m_ctrl = m_ctrl_sh;
            end
            if (host_sel && !host_dphase && host_stb) begin
                if (bus_in[7:4] == 4'h0) begin
                    m_st = 1; m_op = bus_in[3:0];
                end else begin
                    m_st = 0;
                end
            end else if (m_st == 1 && host_sel && host_dphase) begin
                if (m_op >= 8 && m_op <= 11) m_st = 2;
                else if (host_stb) begin
                    case (m_op)
                        4'd0: m_thr = bus_in;
                        4'd1: m_qi_sh = bus_in[4:0] * 2;
                        4'd2: m_qa_sh = bus_in[4:0] * 2;
                        4'd3: m_setup = bus_in & 8'h69;
                        4'd4: m_ctrl_sh = bus_in;
                        default: ;
                    endcase
                    m_st = 0;
                end
            end else if (m_st == 2 && !(host_sel && host_dphase)) begin
                m_st = 0;
            end
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            logic       e_oe;
            logic [7:0] e_bus;
            e_oe  = (m_st == 2) && host_sel && host_dphase;
            e_bus = 8'h00;
            if (e_oe) begin
                case (m_op)
                    4'd8:  e_bus = {4'h0, gob_num};
                    4'd9:  e_bus = {1'b0, ~mb_changing, mb_num};
                    4'd10: e_bus = {1'b0, mb_flags[5], mb_flags[4], mb_flags[3],
                                    mb_flags[2], 1'b0, mb_flags[1], mb_flags[0]};
                    4'd11: e_bus = m_setup;
                    default: e_bus = 8'h00;
                endcase
            end
            chk(var_thresh_o == {m_thr, 6'b0}, "R6 threshold", var_thresh_o, {m_thr, 6'b0});
            chk(q_inter_o == m_qi, "R3 inter quantiser", q_inter_o, m_qi);
            chk(q_intra_o == (m_setup[3] ? m_qa : m_qi), "R4 intra quantiser",
                q_intra_o, m_setup[3] ? m_qa : m_qi);
            chk(setup_o == m_setup, "R5 setup", setup_o, m_setup);
            chk(ctrl_o == m_ctrl, "R7 control", ctrl_o, m_ctrl);
            chk(bus_oe == e_oe, "R11 bus enable", bus_oe, e_oe);
            chk(bus_out == e_bus, "R8 R9 R10 R11 bus data", bus_out, e_bus);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic instr(input logic [7:0] b);
        host_sel = 1; host_dphase = 0; bus_in = b; host_stb = 1;
        tick();
        host_stb = 0;
    endtask

    task automatic wr(input logic [7:0] d);
        host_dphase = 1; bus_in = d; host_stb = 1;
        tick();
        host_stb = 0; host_sel = 0; host_dphase = 0; bus_in = 0;
        tick();
    endtask

    task automatic boundary();
        mb_boundary = 1;
        tick();
        mb_boundary = 0;
        tick();
    endtask

    task automatic rd(input logic [3:0] op, input logic [7:0] exp, input string tag);
        instr({4'h0, op});
        host_dphase = 1; bus_in = 0;
        tick();
        chk(bus_oe == 1'b1, tag, bus_oe, 1);
        chk(bus_out == exp, tag, bus_out, exp);
        tick();
        host_sel = 0; host_dphase = 0;
        #1;
        chk(bus_oe == 1'b0 && bus_out == 8'h00, "R11 drop on deselect", bus_oe, 0);
        tick();
    endtask

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1 reset values
        chk(var_thresh_o == 14'd192, "R1 threshold", var_thresh_o, 192);
        chk(q_inter_o == 6'd62 && q_intra_o == 6'd62, "R1 quantisers", q_inter_o, 62);
        chk(setup_o == 0 && ctrl_o == 0 && bus_oe == 0, "R1 setup/ctrl/oe", setup_o, 0);
        rst_n = 1;
        tick();

        // R6 threshold
        instr(8'h00); wr(8'h0A);
        chk(var_thresh_o == 14'd640, "R6 threshold write", var_thresh_o, 640);

        // R3 inter quantiser, shadowed
        instr(8'h01); wr(8'h07);
        chk(q_inter_o == 6'd62, "R3 held before boundary", q_inter_o, 62);
        boundary();
        chk(q_inter_o == 6'd14, "R3 after boundary", q_inter_o, 14);
        instr(8'h01); wr(8'hF3);
        boundary();
        chk(q_inter_o == 6'd38, "R3 upper bits dropped", q_inter_o, 38);

        // R4 shared then split
        instr(8'h02); wr(8'h03);
        boundary();
        chk(q_intra_o == 6'd38, "R4 shared quantiser", q_intra_o, 38);
        instr(8'h03); wr(8'hFF);
        chk(setup_o == 8'h69, "R5 setup mask", setup_o, 8'h69);
        chk(q_intra_o == 6'd6, "R4 split quantiser", q_intra_o, 6);
        rd(4'd11, 8'h69, "R5 setup readback");

        // R7 control
        instr(8'h04); wr(8'hA5);
        chk(ctrl_o == 8'h00, "R7 held before boundary", ctrl_o, 0);
        boundary();
        chk(ctrl_o == 8'hA5, "R7 after boundary", ctrl_o, 8'hA5);
        instr(8'h04);
        host_dphase = 1; bus_in = 8'h3C; host_stb = 1; mb_boundary = 1;
        tick();
        host_stb = 0; host_sel = 0; host_dphase = 0; mb_boundary = 0;
        chk(ctrl_o == 8'hA5, "R7 write on boundary waits", ctrl_o, 8'hA5);
        boundary();
        chk(ctrl_o == 8'h3C, "R7 next boundary", ctrl_o, 8'h3C);

        // R8 R9 R10 reads
        gob_num = 4'hB;
        rd(4'd8, 8'h0B, "R8 GOB read");
        mb_num = 6'h2A; mb_changing = 0;
        rd(4'd9, 8'h6A, "R9 MB read stable");
        mb_changing = 1;
        rd(4'd9, 8'h2A, "R9 MB read changing");
        mb_flags = 6'b101101;
        rd(4'd10, 8'h59, "R10 decision read");

        // R2 bad upper nibble discards instruction
        instr(8'h10); wr(8'h55);
        chk(var_thresh_o == 14'd640, "R2 discarded instruction", var_thresh_o, 640);

        // R12 unknown opcodes
        instr(8'h05); wr(8'h77);
        chk(var_thresh_o == 14'd640 && setup_o == 8'h69, "R12 opcode 5 ignored", setup_o, 8'h69);
        boundary();
        chk(ctrl_o == 8'h3C && q_inter_o == 6'd38, "R12 no shadow change", ctrl_o, 8'h3C);
        instr(8'h0D);
        host_dphase = 1;
        tick(); tick();
        chk(bus_oe == 1'b0 && bus_out == 8'h00, "R12 opcode 13 not driven", bus_oe, 0);
        host_sel = 0; host_dphase = 0;
        tick();

        // R11 phase drop ends read
        instr(8'h08);
        host_dphase = 1;
        chk(bus_oe == 1'b0, "R11 not yet driven", bus_oe, 0);
        tick();
        chk(bus_oe == 1'b1, "R11 driven in read", bus_oe, 1);
        host_dphase = 0;
        #1;
        chk(bus_oe == 1'b0 && bus_out == 8'h00, "R11 drop on phase", bus_oe, 0);
        host_sel = 0;
        tick(); tick();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule